// File: doc/BRIEF.md
# Instruction Fetch Front End with Control-Transfer Annulment

This block is the front end of a five-stage in-order processor pipeline. It holds the program counter, presents it as the instruction memory address, and captures the returned word together with its address in the fetch-to-decode pipeline register. The register-fetch stage decodes that register: jumps and conditional branches are settled there, and the block picks the next fetch address from three sources. These are the sequential address (current address plus 4), a branch target, or a jump target.

Fetch always guesses the sequential address. When a jump or a taken branch settles in the register-fetch stage, the word being fetched in that same cycle is wrong, so it is replaced by a harmless no-operation word. The program counter loads the settled target, and the correct follow-on instruction arrives one cycle later. A not-taken branch costs nothing. A mode input selects a conservative variant instead: it discards the fetched word behind every jump or branch, and after a not-taken branch it fetches the sequential word again. The operand that a branch tests comes in already bypassed from later stages; the block shows which register it needs. An external stall freezes the block.

Instruction fields used here: opcode in bits [31:26], operand register index in bits [20:16], signed 16-bit word offset in bits [15:0]. The opcodes are 6'h2A jump, 6'h2C branch-if-zero and 6'h2D branch-if-nonzero. The no-operation word defaults to 32'h0000_0000.

Top module: `fe_annul_top`

## Requirements
- R1: A synchronous reset sets the fetch address to RESET_PC (0) and loads the no-operation word (32'h0) into the decode-stage instruction.
- R2: With no control transfer in the decode stage and no stall, each clock advances the fetch address by 4 and moves the fetched word and its address into the decode-stage instruction and address outputs.
- R3: A jump (opcode 6'h2A) in the decode stage loads the operand value with bits [1:0] cleared into the fetch address and replaces the fetched word with the no-operation word.
- R4: A branch-if-zero (opcode 6'h2C) is taken when the operand value is zero. It then loads decode address + 4 + (sign-extended bits [15:0] shifted left by 2) and replaces the fetched word with the no-operation word.
- R5: A branch-if-nonzero (opcode 6'h2D) is taken when the operand value is non-zero, with the same target and annulment as R4.
- R6: With the mode input low, a not-taken branch inserts no bubble: the word fetched behind it enters the decode stage unchanged and fetch advances by 4.
- R7: With the mode input high, any jump or branch in the decode stage replaces the fetched word with the no-operation word. After a not-taken branch the fetch address holds, so the sequential word is fetched again on the next cycle.
- R8: While the stall input is high, the fetch address and the decode-stage instruction and address hold their values.
- R9: A three-instruction loop closed by a taken backward branch repeats every 4 cycles in both modes, with exactly one no-operation slot per iteration.
- R10: The operand register index output always equals bits [20:16] of the decode-stage instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Freeze fetch address and decode register |
| always_annul_i | input | 1 | 1 = discard behind every control transfer, 0 = discard only on redirect |
| imem_addr_o | output | 32 | Fetch address to instruction memory |
| imem_rdata_i | input | 32 | Instruction word read at imem_addr_o, same cycle |
| ra_value_i | input | 32 | Bypassed value of the operand register |
| rf_ra_o | output | 5 | Operand register index of the decode-stage instruction |
| rf_instr_o | output | 32 | Decode-stage instruction |
| rf_pc_o | output | 32 | Address of the decode-stage instruction |

## Verification
The bench builds the block with default parameters: a 32-bit datapath, reset address 0 and an all-zero no-operation word. The bench's 64-word program memory then wraps every address into range, so random jump and branch targets always fetch real words. The all-zero filler makes annulled slots and empty memory look alike, so the directed loop tests use non-zero filler words. This setting brings within reach both modes, taken and not-taken branches with forward and backward offsets, and jump operands with non-zero low bits. It also covers stalls that arrive while a redirect is pending.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam logic [5:0] OPC_JUMP  = 6'h2A;
    localparam logic [5:0] OPC_BRZ   = 6'h2C;
    localparam logic [5:0] OPC_BRNZ  = 6'h2D;

    localparam int unsigned OPC_HI   = 31;
    localparam int unsigned OPC_LO   = 26;
    localparam int unsigned RIDX_HI  = 20;
    localparam int unsigned RIDX_LO  = 16;
    localparam int unsigned OFS_W    = 16;

    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_JUMP = 2'd1,
        XFER_BRZ  = 2'd2,
        XFER_BRNZ = 2'd3
    } xfer_kind_e;

    function automatic xfer_kind_e classify(input logic [5:0] opc);
        xfer_kind_e k;
        case (opc)
            OPC_JUMP: k = XFER_JUMP;
            OPC_BRZ:  k = XFER_BRZ;
            OPC_BRNZ: k = XFER_BRNZ;
            default:  k = XFER_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/fe_resolve.sv
module fe_resolve
    import fe_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] dec_instr,
    input  logic [XLEN-1:0] dec_pc,
    input  logic [XLEN-1:0] opnd,
    input  logic            cons_mode,
    output logic            redirect,
    output logic            discard,
    output logic [XLEN-1:0] target
);
    localparam int unsigned EXT_W = XLEN - OFS_W - 2;

    xfer_kind_e        kind;
    logic              opnd_zero;
    logic [XLEN-1:0]   seq_pc;
    logic [XLEN-1:0]   ofs_bytes;
    logic [XLEN-1:0]   br_target;
    logic [XLEN-1:0]   jmp_target;

    always_comb begin
        kind       = classify(dec_instr[OPC_HI:OPC_LO]);
        opnd_zero  = (opnd == '0);
        seq_pc     = dec_pc + XLEN'(4);
        ofs_bytes  = {{EXT_W{dec_instr[OFS_W-1]}}, dec_instr[OFS_W-1:0], 2'b00};
        br_target  = seq_pc + ofs_bytes;
        jmp_target = {opnd[XLEN-1:2], 2'b00};

        unique case (kind)
            XFER_JUMP: redirect = 1'b1;
            XFER_BRZ:  redirect = opnd_zero;
            XFER_BRNZ: redirect = !opnd_zero;
            default:   redirect = 1'b0;
        endcase

        target  = (kind == XFER_JUMP) ? jmp_target : br_target;
        discard = redirect || (cons_mode && (kind != XFER_NONE));
    end

endmodule

// File: rtl/fe_pc_select.sv
module fe_pc_select #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic            redirect,
    input  logic            discard,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] next_pc
);
    logic [XLEN-1:0] seq_pc;

    always_comb begin
        seq_pc = cur_pc + XLEN'(4);
        if (redirect) begin
            next_pc = target;
        end else if (discard) begin
            next_pc = cur_pc;
        end else begin
            next_pc = seq_pc;
        end
    end

endmodule

// File: rtl/fe_annul_top.sv
module fe_annul_top
    import fe_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] NOP_WORD = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_i,
    input  logic            always_annul_i,
    output logic [XLEN-1:0] imem_addr_o,
    input  logic [XLEN-1:0] imem_rdata_i,
    input  logic [XLEN-1:0] ra_value_i,
    output logic [4:0]      rf_ra_o,
    output logic [XLEN-1:0] rf_instr_o,
    output logic [XLEN-1:0] rf_pc_o
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] ipc;
    } fe_state_t;

    fe_state_t       st_d;
    fe_state_t       st_q;
    logic            redirect;
    logic            discard;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] next_pc;

    fe_resolve #(.XLEN(XLEN)) i_resolve (
        .dec_instr (st_q.instr),
        .dec_pc    (st_q.ipc),
        .opnd      (ra_value_i),
        .cons_mode (always_annul_i),
        .redirect  (redirect),
        .discard   (discard),
        .target    (target)
    );

    fe_pc_select #(.XLEN(XLEN)) i_pc_select (
        .cur_pc   (st_q.pc),
        .redirect (redirect),
        .discard  (discard),
        .target   (target),
        .next_pc  (next_pc)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc    = XLEN'(RESET_PC);
            st_d.instr = XLEN'(NOP_WORD);
            st_d.ipc   = XLEN'(RESET_PC);
        end else if (!stall_i) begin
            st_d.pc    = next_pc;
            st_d.instr = discard ? XLEN'(NOP_WORD) : imem_rdata_i;
            st_d.ipc   = st_q.pc;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr_o = st_q.pc;
    assign rf_instr_o  = st_q.instr;
    assign rf_pc_o     = st_q.ipc;
    assign rf_ra_o     = st_q.instr[RIDX_HI:RIDX_LO];

endmodule

// File: rtl/fe_annul_chk.sv
module fe_annul_chk
    import fe_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    parameter logic [31:0] NOP_WORD = 32'h0000_0000
) (
    input logic            clk,
    input logic            rst,
    input logic            stall_i,
    input logic            always_annul_i,
    input logic [XLEN-1:0] imem_addr_o,
    input logic [XLEN-1:0] imem_rdata_i,
    input logic [XLEN-1:0] ra_value_i,
    input logic [4:0]      rf_ra_o,
    input logic [XLEN-1:0] rf_instr_o,
    input logic [XLEN-1:0] rf_pc_o
);
    logic [5:0] opc;
    assign opc = rf_instr_o[OPC_HI:OPC_LO];

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (imem_addr_o == XLEN'(RESET_PC) && rf_instr_o == XLEN'(NOP_WORD)));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && opc != OPC_JUMP && opc != OPC_BRZ && opc != OPC_BRNZ)
        |=> (imem_addr_o == $past(imem_addr_o) + XLEN'(4) && rf_instr_o == $past(imem_rdata_i)));

    assert_jump_redirect_R3: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && opc == OPC_JUMP)
        |=> (imem_addr_o == {$past(ra_value_i[XLEN-1:2]), 2'b00} && rf_instr_o == XLEN'(NOP_WORD)));

    assert_brz_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && opc == OPC_BRZ && ra_value_i == '0) |=> rf_instr_o == XLEN'(NOP_WORD));

    assert_brnz_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && opc == OPC_BRNZ && ra_value_i != '0) |=> rf_instr_o == XLEN'(NOP_WORD));

    assert_no_bubble_R6: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !always_annul_i &&
         ((opc == OPC_BRZ && ra_value_i != '0) || (opc == OPC_BRNZ && ra_value_i == '0)))
        |=> (rf_instr_o == $past(imem_rdata_i) && imem_addr_o == $past(imem_addr_o) + XLEN'(4)));

    assert_cons_refetch_R7: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && always_annul_i &&
         ((opc == OPC_BRZ && ra_value_i != '0) || (opc == OPC_BRNZ && ra_value_i == '0)))
        |=> ($stable(imem_addr_o) && rf_instr_o == XLEN'(NOP_WORD)));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(imem_addr_o) && $stable(rf_instr_o) && $stable(rf_pc_o)));

    always_comb begin
        assert_ra_field_R10: assert (rf_ra_o == rf_instr_o[RIDX_HI:RIDX_LO]);
    end

endmodule

bind fe_annul_top fe_annul_chk #(
    .XLEN(XLEN), .RESET_PC(RESET_PC), .NOP_WORD(NOP_WORD)
) i_fe_annul_chk (.*);

// File: tb/test_fe_annul_top.sv
module test_fe_annul_top;
    localparam logic [31:0] NOPW = 32'h0000_0000;
    localparam logic [5:0]  O_J  = 6'h2A;
    localparam logic [5:0]  O_BZ = 6'h2C;
    localparam logic [5:0]  O_BN = 6'h2D;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] ra_val = '0;
    logic [31:0] addr, rdata, instr, ipc;
    logic [4:0]  ridx;
    logic [31:0] mem [64];

    int total = 0;
    int bad = 0;
    logic [31:0] m_pc, m_ir, m_ipc;

    always #4 clk = ~clk;

    assign rdata = mem[addr[7:2]];

    fe_annul_top i_fe_annul_top (
        .clk(clk), .rst(rst), .stall_i(stall), .always_annul_i(mode),
        .imem_addr_o(addr), .imem_rdata_i(rdata), .ra_value_i(ra_val),
        .rf_ra_o(ridx), .rf_instr_o(instr), .rf_pc_o(ipc)
    );

    initial begin
        #1600000;
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] r, input logic [15:0] lit);
        return {op, 5'd0, r, lit};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // reference next state, written from the requirements
    task automatic model_step(input bit st, input bit md, input logic [31:0] ra, output string tag);
        logic [5:0]  op;
        bit          tk, ctl;
        logic [31:0] tgt;
        op  = m_ir[31:26];
        ctl = (op == O_J) || (op == O_BZ) || (op == O_BN);
        tk  = (op == O_J) || (op == O_BZ && ra == 0) || (op == O_BN && ra != 0);
        tgt = (op == O_J) ? {ra[31:2], 2'b00}
                          : m_ipc + 32'd4 + {{14{m_ir[15]}}, m_ir[15:0], 2'b00};
        tag = (op == O_J) ? "R3" : (op == O_BZ) ? "R4" : (op == O_BN) ? "R5" : "R2";
        if (ctl && !tk) tag = md ? "R7" : "R6";
        if (st) begin
            tag = "R8";
        end else begin
            m_ipc = m_pc;
            m_ir  = (tk || (md && ctl)) ? NOPW : mem[m_pc[7:2]];
            if (tk) m_pc = tgt;
            else if (!(md && ctl)) m_pc = m_pc + 32'd4;
        end
    endtask

    task automatic step(input bit st, input bit md, input logic [31:0] ra);
        string tag;
        @(negedge clk);
        stall = st; mode = md; ra_val = ra;
        model_step(st, md, ra, tag);
        @(posedge clk);
        #1;
        chk(addr == m_pc, {tag, " fetch address"}, addr, m_pc);
        chk(instr == m_ir, {tag, " decode instr"}, instr, m_ir);
        chk(ipc == m_ipc, {tag, " decode pc"}, ipc, m_ipc);
        chk(ridx == m_ir[20:16], "R10 operand index", {27'd0, ridx}, {27'd0, m_ir[20:16]});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; stall = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
        m_pc = 32'd0; m_ir = NOPW; m_ipc = 32'd0;
        chk(addr == 32'd0, "R1 reset address", addr, 32'd0);
        chk(instr == NOPW, "R1 reset instr", instr, NOPW);
    endtask

    task automatic load_loop();
        for (int i = 0; i < 64; i++) mem[i] = mk(6'h13, 5'd1, 16'(i));
        mem[0] = mk(6'h10, 5'd3, 16'h0001);   // add-like
        mem[1] = mk(6'h11, 5'd4, 16'h0002);   // mul-like
        mem[2] = mk(O_BN, 5'd3, 16'hFFFD);    // back to 0
        mem[3] = mk(6'h12, 5'd5, 16'h0003);   // sub-like
    endtask

    // loop run: count branch and empty slots over 16 cycles
    task automatic loop_run(input bit md, input logic [31:0] ra, output int nbr, output int nnop);
        nbr = 0; nnop = 0;
        for (int c = 0; c < 16; c++) begin
            step(1'b0, md, ra);
            if (instr == mem[2]) nbr++;
            if (instr == NOPW) nnop++;
        end
    endtask

    initial begin
        int nb, nn;
        void'($urandom(32'd4242));

        // directed: loop taken, both modes (R9)
        for (int md = 0; md < 2; md++) begin
            load_loop();
            do_reset();
            loop_run(md[0], 32'd7, nb, nn);
            chk(nb == 4, "R9 branches per 16 cycles", 32'(nb), 32'd4);
            chk(nn == 4, "R9 empty slots per 16 cycles", 32'(nn), 32'd4);
        end

        // directed: not-taken, speculative mode: no bubble (R6)
        load_loop();
        do_reset();
        step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
        chk(instr == mem[2], "R6 branch in decode", instr, mem[2]);
        step(0, 0, 0);
        chk(instr == mem[3], "R6 follow-on without bubble", instr, mem[3]);

        // directed: not-taken, conservative mode: one bubble then refetch (R7)
        do_reset();
        step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
        step(0, 1, 0);
        chk(instr == NOPW, "R7 discarded slot", instr, NOPW);
        step(0, 1, 0);
        chk(instr == mem[3], "R7 refetched follow-on", instr, mem[3]);

        // directed: jump with low operand bits set, stall over it (R3, R8)
        mem[4] = mk(O_J, 5'd9, 16'h0);
        do_reset();
        m_pc = 32'd0;
        step(0, 0, 32'd1); step(0, 0, 32'd1); step(0, 0, 32'd1); step(0, 0, 32'd0);
        step(0, 0, 32'd0);
        step(1, 0, 32'h0000_0033);
        step(1, 0, 32'h0000_0033);
        step(0, 0, 32'h0000_0033);

        // random mix of opcodes, operands, stalls and modes
        for (int i = 0; i < 64; i++) begin
            int sel;
            sel = $urandom_range(0, 7);
            case (sel)
                0: mem[i] = mk(O_J, 5'($urandom), 16'($urandom));
                1, 2: mem[i] = mk(O_BZ, 5'($urandom), 16'($urandom));
                3, 4: mem[i] = mk(O_BN, 5'($urandom), 16'($urandom));
                default: mem[i] = {6'($urandom_range(0, 31)), 26'($urandom)};
            endcase
        end
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom;
            step($urandom_range(0, 5) == 0, n >= 1500, r);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule